// File: doc/BRIEF.md
# Inverter Gate Driver Protection Supervisor

This block gathers every protection event of a three-phase inverter gate driver and decides when all seven gate outputs must be forced off. Three overcurrent comparators feed it: negative-bus current, positive-bus ground fault and the brake/PFC leg. A supply undervoltage flag and the sensed level of a shared enable/fault pin feed it too. Each overcurrent input has its own leading-edge blanking window. The window restarts on every gate turn-on edge, so switching spikes are not taken as faults.

An accepted overcurrent is latched. The latch releases on its own after a programmable number of quiet cycles, which stands in for an external RC delay. Undervoltage shutdown follows the supply flag directly. The block drives the pull-down of the shared open-drain pin, so the pin reads low on a fault. A low level driven onto that pin from outside disables the outputs without being reported as a fault. A sticky cause register tells the controller which event happened, and a read-and-clear strobe empties it.

Top module: `gd_fault_mgr`

## Requirements
- R1: After reset, with no event present and the enable pin high, `shutdown_o`, `flt_pd_o` and `cause_o` are all zero.
- R2: An accepted trip on any of the three overcurrent inputs raises `shutdown_o` combinationally in the same cycle. It sets an overcurrent latch that holds `shutdown_o` after the trip goes away. `flt_pd_o` rises one clock later than `shutdown_o`.
- R3: A pulse on `gate_on_i` blanks each trip input for the cycle of the pulse and the following `BLANK_x_CYC-1` cycles. Negative bus, ground fault and brake/PFC each have their own window length. A trip is accepted in the first cycle after its window ends.
- R4: Once every raw trip input is low, the latch clears at the clock edge that ends the `CLR_CYC`-th consecutive quiet cycle. `shutdown_o` and `flt_pd_o` drop together after that edge.
- R5: If any raw trip input is high while the latch is set, blanked or not, the quiet-cycle count restarts from zero.
- R6: While `uv_i` is high, `shutdown_o` is high in the same cycle, and `flt_pd_o` is high from the next cycle on. Both follow `uv_i` back low with the same timing, and no latch or timer is involved.
- R7: A low level on `en_pad_i` forces `shutdown_o` high in the same cycle. It sets neither `flt_pd_o` nor any cause bit.
- R8: `cause_o` holds bit 0 for undervoltage, bit 1 for negative-bus overcurrent, bit 2 for ground fault and bit 3 for brake/PFC overcurrent. Each bit is sticky until a `cause_clr_i` strobe. An event in the same cycle as the strobe leaves its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trip_neg_i | input | 1 | Negative-bus overcurrent comparator, active high |
| trip_gnd_i | input | 1 | Positive-bus ground-fault comparator, active high |
| trip_aux_i | input | 1 | Brake/PFC overcurrent comparator, active high |
| uv_i | input | 1 | Supply undervoltage flag, active high |
| gate_on_i | input | 1 | One-cycle pulse on each gate turn-on edge |
| en_pad_i | input | 1 | Sensed level of the shared enable/fault pin, low disables |
| cause_clr_i | input | 1 | Read-and-clear strobe for the cause register |
| shutdown_o | output | 1 | Forces all gate outputs off |
| flt_pd_o | output | 1 | Pull-down enable of the open-drain fault pin |
| cause_o | output | 4 | Sticky fault cause bits |

## Verification
The ground-fault input is first driven with no blanking, to show immediate acceptance and the one-cycle lag of the flag behind shutdown. Each trip input is then raised together with a turn-on pulse and held. A check on the exact cycle of acceptance tells the three window lengths apart. A short blanked trip in the middle of an auto-clear delay separates a restarting timer from one that only counts total cycles. The undervoltage, external-disable and simultaneous-trip patterns each show which outputs and cause bits an event is allowed to touch.

// File: rtl/gd_fault_mgr.sv
module gd_fault_mgr #(
  parameter int BLANK_NEG_CYC = 80,
  parameter int BLANK_GND_CYC = 80,
  parameter int BLANK_AUX_CYC = 100,
  parameter int CLR_CYC       = 12000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_neg_i,
  input  logic       trip_gnd_i,
  input  logic       trip_aux_i,
  input  logic       uv_i,
  input  logic       gate_on_i,
  input  logic       en_pad_i,
  input  logic       cause_clr_i,
  output logic       shutdown_o,
  output logic       flt_pd_o,
  output logic [3:0] cause_o
);
  localparam int CW = $clog2(CLR_CYC + 1);

  logic [2:0]    trips;
  logic [2:0]    blank;
  logic [2:0]    hit;
  logic          oc_lat;
  logic [CW-1:0] clr_cnt;
  logic          uv_q;
  logic [3:0]    cause_q;

  assign trips = {trip_aux_i, trip_gnd_i, trip_neg_i};

  for (genvar i = 0; i < 3; i++) begin : g_blank
    localparam int B = (i == 0) ? BLANK_NEG_CYC : (i == 1) ? BLANK_GND_CYC : BLANK_AUX_CYC;
    localparam int W = $clog2(B + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (gate_on_i)  cnt <= W'(B - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign blank[i] = gate_on_i | (cnt != '0);
    assign hit[i]   = trips[i] & ~blank[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_lat  <= 1'b0;
      clr_cnt <= '0;
    end else if (|hit) begin
      oc_lat  <= 1'b1;
      clr_cnt <= '0;
    end else if (|trips) begin
      clr_cnt <= '0;
    end else if (oc_lat) begin
      if (clr_cnt == CW'(CLR_CYC - 1)) begin
        oc_lat  <= 1'b0;
        clr_cnt <= '0;
      end else begin
        clr_cnt <= clr_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q    <= 1'b0;
      cause_q <= '0;
    end else begin
      uv_q    <= uv_i;
      cause_q <= (cause_clr_i ? 4'b0 : cause_q) | {hit, uv_i};
    end
  end

  assign shutdown_o = (|hit) | oc_lat | uv_i | ~en_pad_i;
  assign flt_pd_o   = oc_lat | uv_q;
  assign cause_o    = cause_q;
endmodule

// File: rtl/gd_fault_mgr_chk.sv
module gd_fault_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trip_neg_i,
  input logic       trip_gnd_i,
  input logic       trip_aux_i,
  input logic       uv_i,
  input logic       gate_on_i,
  input logic       en_pad_i,
  input logic       cause_clr_i,
  input logic       shutdown_o,
  input logic       flt_pd_o,
  input logic [3:0] cause_o,
  input logic       oc_lat
);
  AST_FLAG_AFTER_SHUT: assert property (@(posedge clk) disable iff (!rst_n) $rose(flt_pd_o) |-> $past(shutdown_o)); // R2
  AST_LATCH_HOLDS_SHUT: assert property (@(posedge clk) disable iff (!rst_n) oc_lat |-> shutdown_o); // R2
  AST_TURN_ON_BLANKS: assert property (@(posedge clk) disable iff (!rst_n) gate_on_i |=> !$rose(oc_lat)); // R3
  AST_TRIP_HOLDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n) (oc_lat && (trip_neg_i || trip_gnd_i || trip_aux_i)) |=> oc_lat); // R5
  AST_UV_SHUT: assert property (@(posedge clk) disable iff (!rst_n) uv_i |-> shutdown_o); // R6
  AST_EN_SHUT: assert property (@(posedge clk) disable iff (!rst_n) !en_pad_i |-> shutdown_o); // R7
  AST_UV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) uv_i |=> cause_o[0]); // R8
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !cause_clr_i |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R8
endmodule

bind gd_fault_mgr gd_fault_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trip_neg_i(trip_neg_i), .trip_gnd_i(trip_gnd_i),
  .trip_aux_i(trip_aux_i), .uv_i(uv_i), .gate_on_i(gate_on_i), .en_pad_i(en_pad_i),
  .cause_clr_i(cause_clr_i), .shutdown_o(shutdown_o), .flt_pd_o(flt_pd_o),
  .cause_o(cause_o), .oc_lat(oc_lat)
);

// File: tb/gd_fault_mgr_tb.sv
module gd_fault_mgr_tb;
  localparam int BN  = 6;
  localparam int BG  = 8;
  localparam int BA  = 10;
  localparam int CLR = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip_neg_i = 0, trip_gnd_i = 0, trip_aux_i = 0, uv_i = 0, gate_on_i = 0;
  logic en_pad_i = 1, cause_clr_i = 0;
  logic shutdown_o, flt_pd_o;
  logic [3:0] cause_o;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gd_fault_mgr #(.BLANK_NEG_CYC(BN), .BLANK_GND_CYC(BG), .BLANK_AUX_CYC(BA), .CLR_CYC(CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .trip_neg_i(trip_neg_i), .trip_gnd_i(trip_gnd_i),
    .trip_aux_i(trip_aux_i), .uv_i(uv_i), .gate_on_i(gate_on_i), .en_pad_i(en_pad_i),
    .cause_clr_i(cause_clr_i), .shutdown_o(shutdown_o), .flt_pd_o(flt_pd_o), .cause_o(cause_o)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic set_trip(int sel, logic v);
    case (sel)
      0: trip_neg_i = v;
      1: trip_gnd_i = v;
      default: trip_aux_i = v;
    endcase
  endtask

  task automatic clr_cause();
    cause_clr_i = 1'b1; step(); cause_clr_i = 1'b0; step();
  endtask

  task automatic check_autoclear(string req);
    repeat (CLR - 1) step();
    check({req, " still latched"}, {3'b0, shutdown_o}, 4'd1);
    step();
    check({req, " released shutdown"}, {3'b0, shutdown_o}, 4'd0);
    check({req, " released flag"}, {3'b0, flt_pd_o}, 4'd0);
  endtask

  task automatic t_reset();
    #1;
    check("R1 shutdown", {3'b0, shutdown_o}, 0);
    check("R1 flag", {3'b0, flt_pd_o}, 0);
    check("R1 cause", cause_o, 0);
  endtask

  task automatic t_gnd_direct();
    trip_gnd_i = 1; #1;
    check("R2 same-cycle shutdown", {3'b0, shutdown_o}, 1);
    check("R2 flag lags", {3'b0, flt_pd_o}, 0);
    step();
    check("R2 flag set", {3'b0, flt_pd_o}, 1);
    check("R8 gnd cause bit2", cause_o, 4'b0100);
    trip_gnd_i = 0; #1;
    check("R2 latch holds", {3'b0, shutdown_o}, 1);
    check_autoclear("R4");
    clr_cause();
  endtask

  task automatic t_blank(int sel, int b);
    gate_on_i = 1; set_trip(sel, 1); #1;
    check("R3 edge cycle blanked", {3'b0, shutdown_o}, 0);
    for (int k = 1; k < b; k++) begin
      step(); gate_on_i = 0; #1;
      check("R3 inside window", {3'b0, shutdown_o}, 0);
    end
    step();
    check("R3 accepted after window", {3'b0, shutdown_o}, 1);
    step();
    check("R3 flag", {3'b0, flt_pd_o}, 1);
    check("R8 cause bit", cause_o, 4'(1 << (sel + 1)));
    set_trip(sel, 0);
    check_autoclear("R4");
    clr_cause();
  endtask

  task automatic t_restart();
    trip_neg_i = 1; step(); trip_neg_i = 0;
    repeat (CLR / 2) step();
    trip_aux_i = 1; gate_on_i = 1; #1;
    check("R5 blanked trip no new hit", {3'b0, flt_pd_o}, 1);
    step(); trip_aux_i = 0; gate_on_i = 0;
    check("R5 blanked aux no cause", cause_o, 4'b0010);
    check_autoclear("R5");
    clr_cause();
  endtask

  task automatic t_uv();
    uv_i = 1; #1;
    check("R6 uv shutdown", {3'b0, shutdown_o}, 1);
    check("R6 uv flag lags", {3'b0, flt_pd_o}, 0);
    step();
    check("R6 uv flag", {3'b0, flt_pd_o}, 1);
    check("R8 uv cause bit0", cause_o, 4'b0001);
    repeat (3) step();
    uv_i = 0; #1;
    check("R6 uv release shutdown", {3'b0, shutdown_o}, 0);
    step();
    check("R6 uv release flag", {3'b0, flt_pd_o}, 0);
    check("R8 uv sticky", cause_o, 4'b0001);
    clr_cause();
    check("R8 cleared", cause_o, 0);
  endtask

  task automatic t_clr_priority();
    uv_i = 1; cause_clr_i = 1; step();
    uv_i = 0; cause_clr_i = 0;
    check("R8 set beats clear", cause_o, 4'b0001);
    clr_cause();
  endtask

  task automatic t_enable();
    en_pad_i = 0; #1;
    check("R7 ext disable shutdown", {3'b0, shutdown_o}, 1);
    repeat (3) step();
    check("R7 no flag", {3'b0, flt_pd_o}, 0);
    check("R7 no cause", cause_o, 0);
    en_pad_i = 1; #1;
    check("R7 release", {3'b0, shutdown_o}, 0);
  endtask

  task automatic t_multi();
    trip_neg_i = 1; trip_aux_i = 1; step();
    trip_neg_i = 0; trip_aux_i = 0;
    check("R8 two causes", cause_o, 4'b1010);
    check_autoclear("R4 multi");
    clr_cause();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    step();
    t_gnd_direct();
    t_blank(0, BN);
    t_blank(1, BG);
    t_blank(2, BA);
    t_restart();
    t_uv();
    t_clr_priority();
    t_enable();
    t_multi();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule